// File: doc/BRIEF.md
# Seeded PN Bit Whitener

This block makes a serial bit stream look random and later restores it. It uses a 16-bit maximal-length pseudorandom generator. Each accepted bit leaves XORed with the generator's top bit, and the generator then takes one step. XORing the same keystream twice gives back the original bit. So one instance whitens transmit bits and an identical instance, loaded the same way, restores received bits. Voice and supervisory bits are treated alike: every accepted bit is combined with the keystream.

The starting state of the generator is formed from three 16-bit values held outside the block: a software-written seed and two link identifiers. The state is the XOR of all three. When the link controller pulses `link_start`, this state is loaded. The first bit of the frame then uses the top bit of that freshly loaded state, before any shift. A starting value of zero would lock up the generator, so it is replaced by a fixed nonzero constant.

Bits enter and leave over valid/ready handshakes. One output register sits between the two sides.
- A bit is accepted in any cycle where `in_valid` and `in_ready` are both high.
- The result appears on the next cycle and stays stable until the downstream side takes it with `out_ready`.
- `in_ready` is high whenever the output register is empty or is being emptied in the same cycle. This lets one bit per cycle flow with no bubbles.

Top module: `pn_whitener`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1. The generator holds the substitute constant 16'hACE1.
- R2: A bit accepted in cycle n appears in cycle n+1 with `out_valid` high. Its `out_bit` equals the input bit XOR bit 15 of the generator state in effect in cycle n.
- R3: After a `link_start` pulse, the first accepted bit is combined with bit 15 of (`seed_word` XOR `link_id_a` XOR `link_id_b`).
- R4: The generator takes exactly one step per accepted bit, and no step otherwise. The step is a left shift of a Fibonacci register whose new bit 0 is s[15]^s[14]^s[12]^s[3], which implements polynomial x^16+x^15+x^13+x^4+1.
- R5: If the combined start value is zero, the state loaded on `link_start` is 16'hACE1. The generator state is never zero.
- R6: If `link_start` and an accepted bit fall in the same cycle, that bit uses the newly formed start state. The generator then holds one step beyond it.
- R7: While `out_valid` is high and `out_ready` is low, `out_bit` and `out_valid` hold their values and `in_ready` is low.
- R8: With `out_ready` held high and `in_valid` held high, one bit is accepted and one delivered every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_start | input | 1 | Pulse: load the start state |
| seed_word | input | 16 | Software seed value |
| link_id_a | input | 16 | First link identifier |
| link_id_b | input | 16 | Second link identifier |
| in_valid | input | 1 | Input bit present |
| in_ready | output | 1 | Block can accept a bit |
| in_bit | input | 1 | Serial data in |
| out_valid | output | 1 | Output bit present |
| out_ready | input | 1 | Downstream takes the output bit |
| out_bit | output | 1 | Whitened or restored data out |

## Verification
Only bit 15 of the generator reaches the ports, so a wrong state may stay hidden for a while. A wrongly loaded start value shows on the first output bit after `link_start` if its top bit differs. Otherwise it shows within 16 accepted bits, because every state bit shifts into the top position within 15 steps. A generator that steps on stalled or idle cycles slips the keystream, and the error shows on the next accepted bit whose expected key differs. A wrong tap shows once the feedback bits reach bit 15, within 16 to 31 accepted bits. A handshake fault shows at once on `out_valid` or `in_ready` in the stalled cycle.

// File: rtl/pn_whitener_pkg.sv
package pn_whitener_pkg;
  parameter int unsigned PN_W = 16;
  typedef logic [PN_W-1:0] pn_state_t;
  // taps for x^16+x^15+x^13+x^4+1 on state bits 15,14,12,3
  parameter pn_state_t PN_TAPS_DEF = 16'hD008;
  parameter pn_state_t PN_FIX_DEF  = 16'hACE1;

  function automatic pn_state_t pn_step(input pn_state_t s, input pn_state_t taps);
    pn_step = {s[PN_W-2:0], ^(s & taps)};
  endfunction
endpackage

// File: rtl/pn_seed_former.sv
module pn_seed_former
  import pn_whitener_pkg::*;
#(
  parameter pn_state_t FIX = PN_FIX_DEF
) (
  input  pn_state_t seed,
  input  pn_state_t id_a,
  input  pn_state_t id_b,
  output pn_state_t start
);
  pn_state_t mix;
  always_comb begin
    mix   = seed ^ id_a ^ id_b;
    start = (mix == '0) ? FIX : mix;
  end
endmodule

// File: rtl/pn_lfsr.sv
module pn_lfsr
  import pn_whitener_pkg::*;
#(
  parameter pn_state_t TAPS = PN_TAPS_DEF,
  parameter pn_state_t FIX  = PN_FIX_DEF
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  pn_state_t load_val,
  input  logic      advance,
  output pn_state_t state,
  output logic      key
);
  localparam int unsigned MSB = PN_W - 1;
  pn_state_t base, nxt;

  always_comb begin
    base = load ? load_val : state;
    nxt  = advance ? pn_step(base, TAPS) : base;
    key  = base[MSB];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= FIX;
    else        state <= nxt;
  end
endmodule

// File: rtl/pn_xor_stage.sv
module pn_xor_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic key,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_bit,
  output logic out_valid,
  input  logic out_ready,
  output logic out_bit,
  output logic accept
);
  always_comb begin
    in_ready = !out_valid || out_ready;
    accept   = in_valid && in_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_bit   <= in_bit ^ key;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pn_whitener.sv
module pn_whitener
  import pn_whitener_pkg::*;
#(
  parameter pn_state_t TAPS = PN_TAPS_DEF,
  parameter pn_state_t FIX  = PN_FIX_DEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            link_start,
  input  logic [PN_W-1:0] seed_word,
  input  logic [PN_W-1:0] link_id_a,
  input  logic [PN_W-1:0] link_id_b,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic            in_bit,
  output logic            out_valid,
  input  logic            out_ready,
  output logic            out_bit
);
  pn_state_t start_state;
  pn_state_t lfsr_state;
  logic      key;
  logic      accept;

  pn_seed_former #(.FIX(FIX)) u_seed (
    .seed(seed_word), .id_a(link_id_a), .id_b(link_id_b), .start(start_state)
  );

  pn_lfsr #(.TAPS(TAPS), .FIX(FIX)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .load(link_start), .load_val(start_state),
    .advance(accept), .state(lfsr_state), .key(key)
  );

  pn_xor_stage u_xor (
    .clk(clk), .rst_n(rst_n), .key(key),
    .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit),
    .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit),
    .accept(accept)
  );
endmodule

// File: rtl/pn_whitener_chk.sv
module pn_whitener_chk
  import pn_whitener_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      link_start,
  input logic      in_valid,
  input logic      in_ready,
  input logic      in_bit,
  input logic      out_valid,
  input logic      out_ready,
  input logic      out_bit,
  input pn_state_t state,
  input pn_state_t start,
  input logic      key
);
  logic hs;
  assign hs = in_valid && in_ready;

  p_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hs |=> out_valid && (out_bit == ($past(in_bit) ^ $past(key))));

  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (link_start && !hs) |=> state == $past(start));

  p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_start && !hs) |=> $stable(state));

  p_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_bit));

  p_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_flow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> in_ready);
endmodule

bind pn_whitener pn_whitener_chk u_chk (
  .clk(clk), .rst_n(rst_n), .link_start(link_start),
  .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit),
  .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit),
  .state(lfsr_state), .start(start_state), .key(key)
);

// File: tb/test_pn_whitener.sv
module test_pn_whitener;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic link_start = 1'b0;
  logic [15:0] seed_word = '0, link_id_a = '0, link_id_b = '0;
  logic in_valid = 1'b0, in_bit = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid, out_bit;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] m_state;
  logic m_ov, m_ob;

  always #4 clk = ~clk;

  pn_whitener i_pn_whitener (
    .clk(clk), .rst_n(rst_n), .link_start(link_start),
    .seed_word(seed_word), .link_id_a(link_id_a), .link_id_b(link_id_b),
    .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit),
    .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit)
  );

  function automatic logic [15:0] ref_next(input logic [15:0] s);
    logic fb;
    fb = s[15] ^ s[14] ^ s[12] ^ s[3];
    return {s[14:0], fb};
  endfunction

  function automatic logic [15:0] ref_start(input logic [15:0] a, b, c);
    logic [15:0] x;
    x = a ^ b ^ c;
    return (x == 16'h0) ? 16'hACE1 : x;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle: inputs set at negedge, outputs checked at following negedge
  task automatic cyc(input logic v, input logic b, input logic ls, input logic ordy,
                     input string req);
    logic hs;
    logic [15:0] cur;
    in_valid = v; in_bit = b; link_start = ls; out_ready = ordy;
    #1;
    chk(in_ready == (!m_ov || ordy), "R7/R8 in_ready", in_ready, !m_ov || ordy);
    hs  = v && (!m_ov || ordy);
    cur = ls ? ref_start(seed_word, link_id_a, link_id_b) : m_state;
    if (hs) begin
      m_ob    = b ^ cur[15];
      m_ov    = 1'b1;
      m_state = ref_next(cur);
    end else begin
      m_state = cur;
      if (ordy) m_ov = 1'b0;
    end
    @(negedge clk);
    chk(out_valid == m_ov, req, out_valid, m_ov);
    if (m_ov) chk(out_bit == m_ob, req, out_bit, m_ob);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    m_state = 16'hACE1; m_ov = 1'b0; m_ob = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    @(negedge clk);
    // R1: first bit after reset uses ACE1 MSB (1): in 0 -> out 1
    cyc(1, 0, 0, 1, "R1 reset key");

    // R3: start 8000 -> MSB 1
    seed_word = 16'h8000; link_id_a = 16'h1234; link_id_b = 16'h1234;
    cyc(0, 0, 1, 1, "R3 load");
    cyc(1, 0, 0, 1, "R3 first bit");
    chk(m_ob == 1'b1, "R3 model", m_ob, 1);
    // R3: start 7FFF -> MSB 0
    seed_word = 16'h0F0F; link_id_a = 16'h70F0; link_id_b = 16'h0000;
    cyc(0, 0, 1, 1, "R3 load2");
    cyc(1, 1, 0, 1, "R3 first bit2");
    for (int i = 0; i < 20; i++) cyc(1, i[0], 0, 1, "R4 sequence");

    // R5: zero combination -> ACE1
    seed_word = 16'h5A5A; link_id_a = 16'h0FF0; link_id_b = 16'h55AA;
    cyc(0, 0, 1, 1, "R5 load zero");
    for (int i = 0; i < 18; i++) cyc(1, 0, 0, 1, "R5 keystream");

    // R6: load and bit in same cycle
    seed_word = 16'hC001; link_id_a = 16'h0; link_id_b = 16'h0;
    cyc(1, 0, 1, 1, "R6 same cycle");
    for (int i = 0; i < 4; i++) cyc(1, 0, 0, 1, "R6 follow");

    // R7: stall holds output, blocks input
    cyc(1, 1, 0, 0, "R7 fill");
    for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0, "R7 stall");
    cyc(1, 0, 0, 1, "R7 release");

    // R4: idle cycles do not step the generator
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 1, "R4 idle");
    for (int i = 0; i < 17; i++) cyc(1, 1, 0, 1, "R4 after idle");

    // R8: streaming
    for (int i = 0; i < 40; i++) cyc(1, i[1], 0, 1, "R8 stream");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 199) == 0) begin
        seed_word = 16'($urandom); link_id_a = 16'($urandom); link_id_b = 16'($urandom);
        cyc(1'($urandom), 1'($urandom), 1, 1'($urandom), "R3/R6 random");
      end else begin
        cyc(1'($urandom), 1'($urandom), 0, 1'($urandom), "R2 random");
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule